// File: doc/BRIEF.md
# Soft Reset and Clock Gate Controller

This block owns the reset and clock-enable of one peripheral core. Software sees a single control word with two live bits: a soft-reset bit and a clock-gate bit. Each write carries a two-bit operation code: plain write, set, clear or toggle. The code selects how the write data combines with the current word, so software can change one bit without a read-modify-write.

While soft-reset is high the core is held in reset. Once soft-reset has stayed high for a programmable number of cycles, hardware forces the clock-gate bit to 1. Software polls for that bit to learn that the reset has taken hold. It then clears soft-reset, clears the gate, and polls until the gate reads 0. While soft-reset is high, a software write cannot clear the gate bit. The gate is modelled as a clock enable to the core, not as a gating cell.

Top module: `blkrst_ctrl`

## Requirements
- R1: While `rst_n` is low, soft-reset and clock-gate are both 1, `core_rst` is 1 and `core_clk_en` is 0.
- R2: A write (`wr_en` high at a clock edge) uses `wr_op` as follows: 0 loads the data, 1 ORs it in, 2 clears the bits where the data is 1, and 3 inverts the bits where the data is 1. With `wr_en` low the word is unchanged. Soft-reset is data and read bit 31 (SRST_POS).
- R3: Clock-gate is data and read bit 30 (GATE_POS). While soft-reset reads 0, software can set, clear, toggle or load the gate freely, and the gate falls only by such a write.
- R4: If soft-reset first reads 1 in some cycle, clock-gate reads 1 exactly GATE_DELAY cycles later, provided soft-reset has stayed high throughout.
- R5: While soft-reset reads 1, any write that would turn clock-gate from 1 to 0 leaves it at 1. This holds even when the same write clears soft-reset.
- R6: `core_rst` always equals the soft-reset bit, and `core_clk_en` is always the inverse of the clock-gate bit.
- R7: `rd_data` bits other than SRST_POS and GATE_POS always read 0, whatever was written.
- R8: If soft-reset is cleared before GATE_DELAY cycles have passed, the gate is not set. The next rise of soft-reset starts the full delay again.
- R9: The full handshake completes and leaves both bits at 0. The handshake is: clear soft-reset, clear gate, set soft-reset, wait for gate=1, clear soft-reset, clear gate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| wr_en | input | 1 | Write strobe, one word per cycle |
| wr_op | input | 2 | Write operation: load, set, clear, toggle |
| wr_data | input | DATA_W | Write data or bit mask |
| rd_data | output | DATA_W | Current control word |
| core_rst | output | 1 | Reset to the peripheral core, active high |
| core_clk_en | output | 1 | Clock enable to the peripheral core |

## Verification
A wrong delay counter shows up as a gate bit that rises one cycle early or late on `rd_data`, or does not rise at all. The check samples the gate in the cycle it is due. A counter that fails to restart after an aborted reset pulse makes the gate appear early on the next pulse, within GATE_DELAY cycles of the second rise. A wrong clear-protection path lets the gate read 0 in the cycle after a clear write issued during reset. A wrong output mapping shows at once as `core_rst` or `core_clk_en` disagreeing with the read word.

// File: rtl/blkrst_pkg.sv
`timescale 1ns/1ps
package blkrst_pkg;

   typedef enum logic [1:0] {
      OP_LOAD   = 2'd0,
      OP_SET    = 2'd1,
      OP_CLEAR  = 2'd2,
      OP_TOGGLE = 2'd3
   } bus_op_e;

   // One control bit after one write operation
   function automatic logic apply_op(input bus_op_e op, input logic cur, input logic d);
      logic r;
      case (op)
         OP_LOAD:   r = d;
         OP_SET:    r = cur | d;
         OP_CLEAR:  r = cur & ~d;
         default:   r = cur ^ d;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/blkrst_alias.sv
`timescale 1ns/1ps
module blkrst_alias
   import blkrst_pkg::*;
#(
   parameter int NB = 2
) (
   input  bus_op_e          op,
   input  logic [NB-1:0]    cur,
   input  logic [NB-1:0]    din,
   output logic [NB-1:0]    nxt
);

   if (NB < 1) begin : g_bad_nb
      $error("blkrst_alias: NB must be at least 1");
   end

   for (genvar b = 0; b < NB; b++) begin : g_bit
      always_comb nxt[b] = apply_op(op, cur[b], din[b]);
   end

endmodule

// File: rtl/blkrst_gate_timer.sv
`timescale 1ns/1ps
module blkrst_gate_timer #(
   parameter int GATE_DELAY = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic srst,
   output logic hw_set
);

   if (GATE_DELAY < 1) begin : g_bad_delay
      $error("blkrst_gate_timer: GATE_DELAY must be at least 1");
   end

   if (GATE_DELAY == 1) begin : g_direct
      // Gate follows one cycle behind soft-reset
      assign hw_set = srst;
   end else begin : g_count
      localparam int CW = $clog2(GATE_DELAY);
      localparam logic [CW-1:0] LAST = CW'(GATE_DELAY - 1);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt_q <= '0;
         end else if (!srst) begin
            cnt_q <= '0;
         end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end

      assign hw_set = srst && (cnt_q == LAST);
   end

endmodule

// File: rtl/blkrst_ctrl_reg.sv
`timescale 1ns/1ps
module blkrst_ctrl_reg (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_en,
   input  logic nxt_srst,
   input  logic nxt_gate,
   input  logic hw_set,
   output logic srst_q,
   output logic gate_q
);

   logic gate_d;

   always_comb begin
      gate_d = gate_q;
      if (hw_set) begin
         gate_d = 1'b1;
      end else if (wr_en) begin
         // during reset the gate may be raised but never dropped
         gate_d = srst_q ? (gate_q | nxt_gate) : nxt_gate;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         srst_q <= 1'b1;
         gate_q <= 1'b1;
      end else begin
         if (wr_en) srst_q <= nxt_srst;
         gate_q <= gate_d;
      end
   end

endmodule

// File: rtl/blkrst_ctrl.sv
`timescale 1ns/1ps
module blkrst_ctrl
   import blkrst_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int SRST_POS   = 31,
   parameter int GATE_POS   = 30,
   parameter int GATE_DELAY = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_op,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   output logic              core_rst,
   output logic              core_clk_en
);

   localparam int NB = 2;
   localparam int IDX_SRST = 1;
   localparam int IDX_GATE = 0;

   if (SRST_POS >= DATA_W || GATE_POS >= DATA_W || SRST_POS < 0 || GATE_POS < 0) begin : g_bad_pos
      $error("blkrst_ctrl: bit positions must lie inside DATA_W");
   end
   if (SRST_POS == GATE_POS) begin : g_same_pos
      $error("blkrst_ctrl: SRST_POS and GATE_POS must differ");
   end

   logic [NB-1:0] cur_bits, din_bits, nxt_bits;
   logic          srst_q, gate_q, hw_set;

   assign cur_bits[IDX_SRST] = srst_q;
   assign cur_bits[IDX_GATE] = gate_q;
   assign din_bits[IDX_SRST] = wr_data[SRST_POS];
   assign din_bits[IDX_GATE] = wr_data[GATE_POS];

   blkrst_alias #(.NB(NB)) i_alias (
      .op  (bus_op_e'(wr_op)),
      .cur (cur_bits),
      .din (din_bits),
      .nxt (nxt_bits)
   );

   blkrst_gate_timer #(.GATE_DELAY(GATE_DELAY)) i_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .srst   (srst_q),
      .hw_set (hw_set)
   );

   blkrst_ctrl_reg i_reg (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .nxt_srst (nxt_bits[IDX_SRST]),
      .nxt_gate (nxt_bits[IDX_GATE]),
      .hw_set   (hw_set),
      .srst_q   (srst_q),
      .gate_q   (gate_q)
   );

   always_comb begin
      rd_data           = '0;
      rd_data[SRST_POS] = srst_q;
      rd_data[GATE_POS] = gate_q;
   end

   assign core_rst    = srst_q;
   assign core_clk_en = ~gate_q;

endmodule

// File: rtl/blkrst_ctrl_chk.sv
`timescale 1ns/1ps
module blkrst_ctrl_chk #(
   parameter int DATA_W     = 32,
   parameter int SRST_POS   = 31,
   parameter int GATE_POS   = 30,
   parameter int GATE_DELAY = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [DATA_W-1:0] rd_data,
   input logic              core_rst,
   input logic              core_clk_en
);

   localparam int RW = $clog2(GATE_DELAY + 1);
   localparam logic [RW-1:0] LIM = RW'(GATE_DELAY);

   logic          gate_rd, srst_rd;
   logic [RW-1:0] run_cnt;
   logic [DATA_W-1:0] spare_mask;

   assign gate_rd = rd_data[GATE_POS];
   assign srst_rd = rd_data[SRST_POS];

   always_comb begin
      spare_mask           = '1;
      spare_mask[SRST_POS] = 1'b0;
      spare_mask[GATE_POS] = 1'b0;
   end

   // cycles that soft-reset has been observed high without a break
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            run_cnt <= '0;
      else if (!core_rst)    run_cnt <= '0;
      else if (run_cnt != LIM) run_cnt <= run_cnt + 1'b1;
   end

   // R6
   rst_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (core_rst == srst_rd) && (core_clk_en == !gate_rd));

   // R4
   gate_by_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_cnt == LIM) |-> gate_rd);

   // R5
   gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (core_rst && gate_rd) |=> gate_rd);

   // R3
   gate_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(gate_rd) |-> !$past(core_rst));

   // R7
   spare_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data & spare_mask) == '0);

endmodule

bind blkrst_ctrl blkrst_ctrl_chk #(
   .DATA_W     (DATA_W),
   .SRST_POS   (SRST_POS),
   .GATE_POS   (GATE_POS),
   .GATE_DELAY (GATE_DELAY)
) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .rd_data     (rd_data),
   .core_rst    (core_rst),
   .core_clk_en (core_clk_en)
);

// File: tb/test_blkrst_ctrl.sv
`timescale 1ns/1ps
module test_blkrst_ctrl;
   import blkrst_pkg::*;

   localparam int DW = 32;
   localparam logic [DW-1:0] S = 32'h8000_0000;
   localparam logic [DW-1:0] G = 32'h4000_0000;

   typedef struct {
      logic s;
      logic g;
      string req;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          wr_en;
   logic [1:0]    wr_op;
   logic [DW-1:0] wr_data;
   logic [DW-1:0] rd_data;
   logic          core_rst, core_clk_en;

   int   total = 0;
   int   bad = 0;
   bit   done = 0;
   exp_t exp_q[$];

   always #4 clk = ~clk;

   blkrst_ctrl #(.DATA_W(DW), .SRST_POS(31), .GATE_POS(30), .GATE_DELAY(4)) i_blkrst_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (wr_en),
      .wr_op       (wr_op),
      .wr_data     (wr_data),
      .rd_data     (rd_data),
      .core_rst    (core_rst),
      .core_clk_en (core_clk_en)
   );

   task automatic compare(input logic s, input logic g, input string req);
      logic [DW-1:0] want;
      want = (s ? S : '0) | (g ? G : '0);
      total++;
      if (rd_data !== want || core_rst !== s || core_clk_en !== !g) begin
         bad++;
         $display("FAIL %s: rd=%h rst=%b en=%b expected rd=%h rst=%b en=%b",
                  req, rd_data, core_rst, core_clk_en, want, s, !g);
      end
   endtask

   // driver: one cycle of stimulus, expectation for the state after the next edge
   task automatic cyc(input bit en, input bus_op_e op, input logic [DW-1:0] d,
                      input logic s, input logic g, input string req);
      exp_t e;
      @(negedge clk);
      wr_en   = en;
      wr_op   = op;
      wr_data = d;
      e.s = s; e.g = g; e.req = req;
      exp_q.push_back(e);
   endtask

   task automatic idle(input logic s, input logic g, input string req);
      cyc(1'b0, OP_LOAD, '0, s, g, req);
   endtask

   // monitor: compares after each edge
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            compare(e.s, e.g, e.req);
         end
      end
   end

   initial begin
      rst_n = 1'b0; wr_en = 1'b0; wr_op = 2'd0; wr_data = '0;
      repeat (3) @(posedge clk);
      #2;
      compare(1'b1, 1'b1, "R1 power-on state");
      @(negedge clk);
      rst_n = 1'b1;
      idle(1, 1, "R1 after release");

      // R9 handshake with R2 clear alias and R4 timing
      cyc(1, OP_CLEAR, S, 0, 1, "R2 clear srst");
      cyc(1, OP_CLEAR, G, 0, 0, "R3 clear gate");
      cyc(1, OP_SET,   S, 1, 0, "R2 set srst");
      idle(1, 0, "R4 delay 1");
      idle(1, 0, "R4 delay 2");
      idle(1, 0, "R4 delay 3");
      idle(1, 1, "R4 gate set on time");
      cyc(1, OP_CLEAR,  G, 1, 1, "R5 clear gate ignored");
      cyc(1, OP_TOGGLE, G, 1, 1, "R5 toggle gate ignored");
      cyc(1, OP_LOAD,   S, 1, 1, "R5 load gate 0 ignored");
      cyc(1, OP_CLEAR,  S, 0, 1, "R9 release srst");
      cyc(1, OP_CLEAR,  G, 0, 0, "R9 ungate");
      idle(0, 0, "R9 settled");

      // R8 aborted pulse then full restart
      cyc(1, OP_SET, S, 1, 0, "R8 set srst");
      idle(1, 0, "R8 early 1");
      idle(1, 0, "R8 early 2");
      cyc(1, OP_CLEAR, S, 0, 0, "R8 abort");
      idle(0, 0, "R8 no gate 1");
      idle(0, 0, "R8 no gate 2");
      idle(0, 0, "R8 no gate 3");
      idle(0, 0, "R8 no gate 4");
      cyc(1, OP_SET, S, 1, 0, "R8 rise again");
      idle(1, 0, "R8 restart 1");
      idle(1, 0, "R8 restart 2");
      idle(1, 0, "R8 restart 3");
      idle(1, 1, "R8 restart full delay");

      // R2 toggle, R3 software control of gate, R5 combined write
      cyc(1, OP_TOGGLE, S, 0, 1, "R2 toggle srst");
      cyc(1, OP_TOGGLE, G, 0, 0, "R3 toggle gate");
      cyc(1, OP_SET,    G, 0, 1, "R3 set gate");
      cyc(1, OP_LOAD,   '0, 0, 0, "R3 load zero");
      cyc(0, OP_SET,    S | G, 0, 0, "R2 no write strobe");
      cyc(1, OP_LOAD,   S | G, 1, 1, "R2 load both");
      cyc(1, OP_LOAD,   '0, 0, 1, "R5 combined clear keeps gate");
      cyc(1, OP_CLEAR,  G, 0, 0, "R3 clear gate");
      cyc(1, OP_SET,    '1, 1, 1, "R7 set all ones");
      cyc(1, OP_CLEAR,  '1, 0, 1, "R7 clear all ones");
      cyc(1, OP_TOGGLE, ~(S | G), 0, 1, "R7 toggle spare bits");
      idle(0, 1, "R7 final");

      wait (exp_q.size() == 0);
      repeat (2) @(posedge clk);
      done = 1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            bad++;
            total++;
            $display("FAIL watchdog: run did not finish, expected completion");
         end
      join_any
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule